// File: doc/BRIEF.md
# Bit-Serial Compare-and-Exchange Sorting Cell

This block is one 2x2 cell of a sorting network that works on bit-serial packets. Two packets enter in lockstep, one bit per clock on each side. Each packet opens with a destination address of `ADDR_W` bits, sent most significant bit first, and the payload follows. The cell compares the two addresses as their bits arrive. It fixes its 2x2 crossbar at the first bit position where the addresses disagree. It then sends both packets on, address included, with the larger address on the output that its direction parameter selects.

Each input has a delay line of `ADDR_W` stages. The head of a packet therefore reaches the crossbar exactly when the comparison is complete. Each side has a start strobe that marks the cycle of its first address bit, and an occupancy flag that is sampled with that strobe. A side whose flag is low carries an empty packet, and an empty packet ranks above any address. A comparison window opens only after both start strobes have been seen.

Top module: `bitserial_sort_cell`

## Requirements
- R1: Each output bit equals an input bit delayed by exactly `ADDR_W` clock cycles. The whole packet, address prefix included, passes through unchanged. After reset both outputs are 0 and the crossbar is straight (`dout_up` follows side A, `dout_dn` follows side B).
- R2: With `DESCEND`=0, the packet with the larger address leaves on `dout_up` and the other leaves on `dout_dn`.
- R3: With `DESCEND`=1, the packet with the larger address leaves on `dout_dn` and the other leaves on `dout_up`.
- R4: The addresses are compared from the most significant bit down. Only the first differing bit position decides the order, and all later address bits are ignored.
- R5: When the two addresses are equal, the crossbar stays straight for that packet pair.
- R6: A side whose occupancy flag is 0 when its start strobe is sampled counts as larger than any address. When both sides are empty, the crossbar is straight.
- R7: A comparison window starts in the cycle where the later of the two start strobes arrives, or in the cycle where both arrive together. It covers that cycle and the next `ADDR_W`-1 cycles. A lone strobe from one side starts nothing. It is remembered until the other side's strobe arrives.
- R8: The new crossbar setting takes effect at the clock edge that ends the comparison window. It therefore applies from the first address bit of the new pair onward. It holds through the whole packet until the next window ends, so packets sent back to back are each routed by their own decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_a | input | 1 | Start strobe for side A; high with its first address bit |
| init_b | input | 1 | Start strobe for side B; high with its first address bit |
| occ_a | input | 1 | Side A carries a real packet (sampled with `init_a`) |
| occ_b | input | 1 | Side B carries a real packet (sampled with `init_b`) |
| din_a | input | 1 | Serial data, side A |
| din_b | input | 1 | Serial data, side B |
| dout_up | output | 1 | Upper serial output |
| dout_dn | output | 1 | Lower serial output |

## Verification
The difficult cycle comes when packets run back to back. In that case the edge that ends one window loads the new crossbar setting. The last payload bit of the previous pair leaves in the cycle just before that edge, and the first address bit of the new pair leaves just after it. A new decision can also fall on the very first cycle of a window, because an empty side decides at once. The bench sends streams with no gap between packets, in which the decision flips from pair to pair. It compares both outputs of an ascending cell and a descending cell against a per-cycle model on every cycle. A crossbar that switched one edge early or one edge late would corrupt a bit at the boundary.

// File: rtl/sort_cell_pkg.sv
`timescale 1ns/1ps
package sort_cell_pkg;

    // Crossbar setting: straight keeps sides on their own lanes.
    typedef enum logic {
        XBAR_STRAIGHT = 1'b0,
        XBAR_SWAPPED  = 1'b1
    } xbar_e;

    // One serial bit on each of the two lanes.
    typedef struct packed {
        logic lane_a;
        logic lane_b;
    } lane_pair_t;

    // Running verdict of a comparison window.
    typedef struct packed {
        logic settled;   // a differing position has been seen
        logic a_wins;    // side A holds the larger key
    } verdict_t;

    // Crossbar setting for a settled verdict.
    // Ascending: the larger key goes up, so swap when B wins.
    // Descending: the larger key goes down, so swap when A wins.
    function automatic xbar_e xbar_for(input logic a_wins, input logic descend);
        return (a_wins ^ ~descend) ? XBAR_SWAPPED : XBAR_STRAIGHT;
    endfunction

endpackage

// File: rtl/sort_cell_delay.sv
`timescale 1ns/1ps
module sort_cell_delay #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stage;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage <= '0;
                else     stage <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage <= '0;
                else     stage <= {stage[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/sort_cell_judge.sv
`timescale 1ns/1ps
module sort_cell_judge
    import sort_cell_pkg::*;
#(
    parameter int   KEY_W   = 4,
    parameter logic DESCEND = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  init_a,
    input  logic  init_b,
    input  logic  occ_a,
    input  logic  occ_b,
    input  lane_pair_t live,
    output xbar_e xbar,
    output logic  win_end
);
    localparam int IDX_W = (KEY_W > 1) ? $clog2(KEY_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_W - 1);
    localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

    // Start bookkeeping
    logic pend_a, pend_b;
    logic occ_hold_a, occ_hold_b;
    logic arm;
    logic occ_now_a, occ_now_b;

    // Window state
    logic             active;
    logic [IDX_W-1:0] idx;
    logic             void_a_q, void_b_q;
    verdict_t         vq;

    // Per-cycle view
    logic             in_win;
    logic [IDX_W-1:0] pos;
    logic             void_a, void_b;
    verdict_t         v_base, v_next;
    logic             void_split, both_void, hit, hit_a_wins;

    always_comb begin
        arm       = (pend_a | init_a) & (pend_b | init_b);
        occ_now_a = init_a ? occ_a : occ_hold_a;
        occ_now_b = init_b ? occ_b : occ_hold_b;
        in_win    = arm | active;
        pos       = arm ? '0 : idx;
        win_end   = in_win && (pos == LAST_IDX);

        void_a    = arm ? ~occ_now_a : void_a_q;
        void_b    = arm ? ~occ_now_b : void_b_q;
        v_base    = arm ? verdict_t'(2'b00) : vq;

        void_split = void_a ^ void_b;
        both_void  = void_a & void_b;
        hit        = in_win && !v_base.settled &&
                     (void_split || (!both_void && (live.lane_a ^ live.lane_b)));
        hit_a_wins = void_split ? void_a : live.lane_a;

        v_next.settled = v_base.settled | hit;
        v_next.a_wins  = hit ? hit_a_wins : v_base.a_wins;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_a     <= 1'b0;
            pend_b     <= 1'b0;
            occ_hold_a <= 1'b0;
            occ_hold_b <= 1'b0;
            active     <= 1'b0;
            idx        <= '0;
            void_a_q   <= 1'b0;
            void_b_q   <= 1'b0;
            vq         <= '0;
            xbar       <= XBAR_STRAIGHT;
        end else begin
            pend_a <= arm ? 1'b0 : (pend_a | init_a);
            pend_b <= arm ? 1'b0 : (pend_b | init_b);
            if (init_a) occ_hold_a <= occ_a;
            if (init_b) occ_hold_b <= occ_b;

            active <= in_win && !win_end;
            if (arm)         idx <= ONE_IDX;
            else if (active) idx <= idx + ONE_IDX;

            if (arm) begin
                void_a_q <= ~occ_now_a;
                void_b_q <= ~occ_now_b;
            end
            if (in_win) vq <= v_next;

            if (win_end)
                xbar <= v_next.settled ? xbar_for(v_next.a_wins, DESCEND)
                                       : XBAR_STRAIGHT;
        end
    end

    // Once a window has a verdict, later bits cannot alter it.
    assert_verdict_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (vq.settled && !arm) |=> (vq.settled && $stable(vq.a_wins)));

    // Unsettled window ends straight.
    assert_tie_straight_R5: assert property (@(posedge clk) disable iff (rst)
        (win_end && !v_next.settled) |=> (xbar == XBAR_STRAIGHT));

    // A lopsided occupancy settles on the first window cycle.
    assert_void_first_R6: assert property (@(posedge clk) disable iff (rst)
        (arm && (occ_now_a != occ_now_b)) |=> vq.settled);

    // A lone strobe opens no window.
    assert_lone_start_R7: assert property (@(posedge clk) disable iff (rst)
        (init_a && !init_b && !pend_b && !active) |=> !active);

    // A finished window closes unless re-armed.
    assert_window_close_R7: assert property (@(posedge clk) disable iff (rst)
        (active && !arm && win_end) |=> !active);

    // Setting only moves at a window end.
    assert_xbar_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(xbar));

endmodule

// File: rtl/sort_cell_xbar.sv
`timescale 1ns/1ps
module sort_cell_xbar
    import sort_cell_pkg::*;
(
    input  lane_pair_t held,
    input  xbar_e      setting,
    output logic       up,
    output logic       dn
);
    always_comb begin
        if (setting == XBAR_SWAPPED) begin
            up = held.lane_b;
            dn = held.lane_a;
        end else begin
            up = held.lane_a;
            dn = held.lane_b;
        end
    end
endmodule

// File: rtl/bitserial_sort_cell.sv
`timescale 1ns/1ps
module bitserial_sort_cell
    import sort_cell_pkg::*;
#(
    parameter int   ADDR_W  = 4,
    parameter logic DESCEND = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic init_a,
    input  logic init_b,
    input  logic occ_a,
    input  logic occ_b,
    input  logic din_a,
    input  logic din_b,
    output logic dout_up,
    output logic dout_dn
);
    lane_pair_t live, held;
    xbar_e      setting;
    logic       win_end;

    assign live.lane_a = din_a;
    assign live.lane_b = din_b;

    sort_cell_delay #(.DEPTH(ADDR_W)) u_dly_a (
        .clk(clk), .rst(rst), .din(din_a), .dout(held.lane_a)
    );
    sort_cell_delay #(.DEPTH(ADDR_W)) u_dly_b (
        .clk(clk), .rst(rst), .din(din_b), .dout(held.lane_b)
    );

    sort_cell_judge #(.KEY_W(ADDR_W), .DESCEND(DESCEND)) u_judge (
        .clk(clk), .rst(rst),
        .init_a(init_a), .init_b(init_b),
        .occ_a(occ_a), .occ_b(occ_b),
        .live(live), .xbar(setting), .win_end(win_end)
    );

    sort_cell_xbar u_xbar (
        .held(held), .setting(setting), .up(dout_up), .dn(dout_dn)
    );

    // Crossbar neither creates nor loses bits.
    assert_bits_conserved_R1: assert property (@(posedge clk) disable iff (rst)
        $countones({dout_up, dout_dn}) == $countones({held.lane_a, held.lane_b}));

endmodule

// File: tb/tb_bitserial_sort_cell.sv
`timescale 1ns/1ps
module tb_bitserial_sort_cell;
    localparam int LA  = 4;
    localparam int PAY = 8;
    localparam int HN  = 8192;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic init_a, init_b, occ_a, occ_b, din_a, din_b;
    logic up_asc, dn_asc, up_dsc, dn_dsc;

    bitserial_sort_cell #(.ADDR_W(LA), .DESCEND(1'b0)) dut (
        .clk(clk), .rst(rst), .init_a(init_a), .init_b(init_b),
        .occ_a(occ_a), .occ_b(occ_b), .din_a(din_a), .din_b(din_b),
        .dout_up(up_asc), .dout_dn(dn_asc)
    );
    bitserial_sort_cell #(.ADDR_W(LA), .DESCEND(1'b1)) dut_dsc (
        .clk(clk), .rst(rst), .init_a(init_a), .init_b(init_b),
        .occ_a(occ_a), .occ_b(occ_b), .din_a(din_a), .din_b(din_b),
        .dout_up(up_dsc), .dout_dn(dn_dsc)
    );

    logic  hist_a [HN];
    logic  hist_b [HN];
    logic  sched  [HN];
    logic  sw_asc [HN];
    logic  sw_dsc [HN];
    string tg_asc [HN];
    string tg_dsc [HN];

    int    cyc, n_chk, n_fail;
    logic  cur_asc, cur_dsc, done;
    string cur_tag_asc, cur_tag_dsc;

    task automatic judge(input string tag, input string who,
                         input logic gu, input logic gd,
                         input logic eu, input logic ed);
        n_chk++;
        if (gu !== eu || gd !== ed) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: up/dn got %b%b expected %b%b",
                     tag, who, cyc, gu, gd, eu, ed);
        end
    endtask

    // Check outputs at the start of cycle cyc, then drive cycle cyc.
    task automatic step(input logic ba, input logic bb, input logic ia,
                        input logic ib, input logic oa, input logic ob);
        logic ea, eb;
        @(negedge clk);
        if (cyc < HN && sched[cyc]) begin
            cur_asc     = sw_asc[cyc];
            cur_dsc     = sw_dsc[cyc];
            cur_tag_asc = tg_asc[cyc];
            cur_tag_dsc = tg_dsc[cyc];
        end
        if (cyc >= LA && cyc - LA < HN) begin
            ea = hist_a[cyc-LA];
            eb = hist_b[cyc-LA];
        end else begin
            ea = 1'b0;
            eb = 1'b0;
        end
        judge(cur_tag_asc, "ascending", up_asc, dn_asc,
              cur_asc ? eb : ea, cur_asc ? ea : eb);
        judge(cur_tag_dsc, "descending", up_dsc, dn_dsc,
              cur_dsc ? eb : ea, cur_dsc ? ea : eb);
        din_a  = ba;
        din_b  = bb;
        init_a = ia;
        init_b = ib;
        occ_a  = oa;
        occ_b  = ob;
        if (cyc < HN) begin
            hist_a[cyc] = ba;
            hist_b[cyc] = bb;
        end
        cyc++;
    endtask

    // {settled, a_wins} from the requirements (R4, R5, R6)
    function automatic logic [1:0] verdict(input logic [LA-1:0] ka, input logic [LA-1:0] kb,
                                           input logic oa, input logic ob);
        if (oa != ob)        return {1'b1, ~oa};
        if (!oa || ka == kb) return 2'b00;
        return {1'b1, (ka > kb)};
    endfunction

    task automatic packet(input logic [LA-1:0] ka, input logic [LA-1:0] kb,
                          input logic oa, input logic ob,
                          input logic ia, input logic ib,
                          input string ta, input string td);
        logic [1:0] v;
        v = verdict(ka, kb, oa, ob);
        if (cyc + LA < HN) begin
            sched[cyc+LA]  = 1'b1;
            sw_asc[cyc+LA] = v[1] & ~v[0];  // R2: B larger -> swap
            sw_dsc[cyc+LA] = v[1] &  v[0];  // R3: A larger -> swap
            tg_asc[cyc+LA] = ta;
            tg_dsc[cyc+LA] = td;
        end
        for (int k = 0; k < LA + PAY; k++) begin
            logic ba, bb;
            ba = (k < LA) ? ka[LA-1-k] : 1'($urandom);
            bb = (k < LA) ? kb[LA-1-k] : 1'($urandom);
            step(ba, bb, (k == 0) ? ia : 1'b0, (k == 0) ? ib : 1'b0, oa, ob);
        end
    endtask

    task automatic idle();
        step(1'($urandom), 1'($urandom), 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        done = 1'b0;
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < HN; i++) begin
            sched[i] = 1'b0; sw_asc[i] = 1'b0; sw_dsc[i] = 1'b0;
            hist_a[i] = 1'b0; hist_b[i] = 1'b0;
        end
        n_chk = 0; n_fail = 0; cyc = 0;
        cur_asc = 1'b0; cur_dsc = 1'b0;
        cur_tag_asc = "R1"; cur_tag_dsc = "R1";   // reset state: zeros, straight
        void'($urandom(32'h5EED_C311));
        init_a = 0; init_b = 0; occ_a = 1; occ_b = 1; din_a = 0; din_b = 0;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state checked on the first steps
        idle(); idle();
        // R4: MSB decides, lower bits opposite
        packet(4'b1000, 4'b0111, 1, 1, 1, 1, "R4", "R4");
        packet(4'b0110, 4'b1001, 1, 1, 1, 1, "R4", "R4");
        packet(4'b1101, 4'b1110, 1, 1, 1, 1, "R4", "R4");
        // R5: equal addresses
        packet(4'b0101, 4'b0101, 1, 1, 1, 1, "R5", "R5");
        // R6: empty sides
        packet(4'b0011, 4'b1100, 0, 1, 1, 1, "R6", "R6");
        packet(4'b1111, 4'b0000, 1, 0, 1, 1, "R6", "R6");
        packet(4'b1010, 4'b0001, 0, 0, 1, 1, "R6", "R6");
        // R8: back-to-back flips
        packet(4'b0001, 4'b1110, 1, 1, 1, 1, "R8", "R8");
        packet(4'b1110, 4'b0001, 1, 1, 1, 1, "R8", "R8");
        packet(4'b0001, 4'b0010, 1, 1, 1, 1, "R8", "R8");
        // R7: lone strobe on A, nothing starts; B strobe later arms the window
        packet(4'b0000, 4'b1111, 1, 1, 1, 1, "R7", "R7");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        idle(); idle(); idle(); idle(); idle(); idle();
        packet(4'b1011, 4'b0100, 1, 1, 1'b0, 1'b1, "R7", "R7");
        // R7: lone strobe on B with an empty A arriving later
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        idle();
        packet(4'b0000, 4'b0110, 0, 1, 1'b1, 1'b0, "R7", "R7");

        // random traffic
        for (int p = 0; p < 150; p++) begin
            logic [LA-1:0] ka, kb;
            logic oa, ob;
            ka = LA'($urandom);
            kb = ($urandom % 6 == 0) ? ka : LA'($urandom);
            oa = ($urandom % 8) != 0;
            ob = ($urandom % 8) != 0;
            packet(ka, kb, oa, ob, 1'b1, 1'b1, "R2", "R3");
            if ($urandom % 3 == 0) idle();
        end
        for (int i = 0; i < LA + 2; i++) idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule